// File: doc/BRIEF.md
# Bus Master Security Filter

This block sits between a single bus master and the port of a downstream memory. It judges every read and write against a security policy. Each access address goes to a small range table. The table reports whether the address is exempt from checking, open to non-secure traffic, or reserved for secure traffic. Using that result and the master's configured security state, the filter takes one of four actions. It forwards the access tagged secure, forwards it tagged non-secure, blocks it so that it reads as zero and writes are dropped, or blocks it with an error response.

Error blocks raise a sticky interrupt, and a clear input resets that interrupt. Three level inputs control the policy: whether the master is non-secure, whether blocked accesses answer with an error, and the interrupt clear. The two policy inputs are registered, so a change takes effect from the next clock edge. The filter keeps at most one access in flight. A forwarded access reaches the downstream port with its address, size and data unchanged, and the downstream read data and error are passed back unchanged.

Top module: `bm_sec_filter`

## Requirements
- R1: For an exempt address (range 0, 0x0000_0000 to 0x0000_0FFF), the access is forwarded. dn_nonsec_o is 1 when the master is configured non-secure and 0 when it is configured secure.
- R2: For a non-exempt address attributed non-secure, the access is forwarded with dn_nonsec_o = 1 under either master configuration.
- R3: For a secure-attributed address (range 1, 0x1000_0000 to 0x1000_FFFF), a master configured secure gets the access forwarded with dn_nonsec_o = 0.
- R4: When a master configured non-secure accesses a secure-attributed address, the access is blocked and dn_valid_o never rises for it.
- R5: With cfg_err_resp_i low, a blocked access responds with rsp_err_o = 0. A blocked read returns rsp_rdata_o = 0, and a blocked write reaches nothing downstream.
- R6: With cfg_err_resp_i high, a blocked access responds with rsp_err_o = 1 and sets the sticky interrupt. The interrupt is not set if irq_clear_i is high at the clock edge that accepts the access.
- R7: When irq_clear_i is high at a clock edge, irq_o is 0 after that edge. Otherwise irq_o keeps its value until a new error block occurs.
- R8: After reset, irq_o, rsp_valid_o and dn_valid_o are 0. Both policy configurations read as 0 (master secure, read-as-zero blocking) until the first edge after reset.
- R9: A forwarded access presents the same address, the same size code (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8) and the same little-endian write data downstream. The response carries the downstream read data and error unchanged.
- R10: dn_valid_o is a one-cycle pulse in the cycle after the request. The upstream response is a one-cycle pulse. It comes in the cycle after dn_rsp_valid_i for a forwarded access, and in the cycle after the request for a blocked one.
- R11: Ranges are checked with range 0 at the highest priority. Range 3 (0x1000_8000 to 0x1001_0FFF, non-secure) loses to range 1 where they overlap. An address that matches no range is non-secure and not exempt.
- R12: A change on cfg_nonsec_i or cfg_err_resp_i in the same cycle as a request does not affect that request. The value is sampled at the edge that accepts it.
- R13: While an access waits for its downstream response, new requests are ignored. They produce no response, no downstream request and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_nonsec_i | input | 1 | Master is non-secure |
| cfg_err_resp_i | input | 1 | Blocked accesses answer with an error |
| irq_clear_i | input | 1 | Clears and holds off the interrupt |
| irq_o | output | 1 | Sticky interrupt on error blocks |
| req_valid_i | input | 1 | Upstream request strobe |
| req_write_i | input | 1 | Request is a write |
| req_addr_i | input | 32 | Request address |
| req_size_i | input | 2 | Size code (log2 of bytes) |
| req_wdata_i | input | 64 | Write data, little-endian lanes |
| rsp_valid_o | output | 1 | Upstream response strobe |
| rsp_err_o | output | 1 | Response is an error |
| rsp_rdata_o | output | 64 | Read data |
| dn_valid_o | output | 1 | Downstream request strobe |
| dn_write_o | output | 1 | Downstream write |
| dn_addr_o | output | 32 | Downstream address |
| dn_size_o | output | 2 | Downstream size code |
| dn_wdata_o | output | 64 | Downstream write data |
| dn_nonsec_o | output | 1 | Downstream security tag, 1 = non-secure |
| dn_rsp_valid_i | input | 1 | Downstream response strobe |
| dn_rsp_err_i | input | 1 | Downstream error |
| dn_rdata_i | input | 64 | Downstream read data |

## Verification
Two things can coincide in one cycle: an error block that would set the interrupt, and a held interrupt clear. The bench raises irq_clear_i on the same cycle as error-mode blocked requests. It expects the interrupt to stay low, and also expects it to drop when a clear meets a status bit that is already set. A second collision pairs a policy-input change with a request. The bench judges that the old sampled policy decides that request.

// File: rtl/bmsf_pkg.sv
package bmsf_pkg;
  typedef enum logic [1:0] {
    ACT_ERR = 2'd0,
    ACT_RAZ = 2'd1,
    ACT_SEC = 2'd2,
    ACT_NS  = 2'd3
  } act_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } st_e;

  typedef struct packed {
    logic exempt;
    logic nonsec;
  } attr_t;
endpackage

// File: rtl/bmsf_attr_table.sv
module bmsf_attr_table
  import bmsf_pkg::*;
#(
  parameter int AW = 32,
  parameter int NREG = 4,
  parameter logic [NREG*AW-1:0] BASE = '0,
  parameter logic [NREG*AW-1:0] LIMIT = '0,
  parameter logic [NREG-1:0] EX_MASK = '0,
  parameter logic [NREG-1:0] NS_MASK = '0
) (
  input  logic [AW-1:0] addr_i,
  output attr_t         attr_o
);
  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_rng
    logic [AW-1:0] lo, hi;
    assign lo = BASE[g*AW +: AW];
    assign hi = LIMIT[g*AW +: AW];
    assign hit[g] = (addr_i >= lo) && (addr_i <= hi);
  end

  // lowest index wins; walk down so it is assigned last
  always_comb begin
    attr_o.exempt = 1'b0;
    attr_o.nonsec = 1'b1;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        attr_o.exempt = EX_MASK[i];
        attr_o.nonsec = NS_MASK[i];
      end
    end
  end
endmodule

// File: rtl/bmsf_decide.sv
module bmsf_decide
  import bmsf_pkg::*;
(
  input  attr_t attr_i,
  input  logic  cfg_ns_i,
  input  logic  cfg_err_i,
  output act_e  act_o
);
  always_comb begin
    if (attr_i.exempt)      act_o = cfg_ns_i ? ACT_NS : ACT_SEC;
    else if (attr_i.nonsec) act_o = ACT_NS;
    else if (!cfg_ns_i)     act_o = ACT_SEC;
    else                    act_o = cfg_err_i ? ACT_ERR : ACT_RAZ;
  end
endmodule

// File: rtl/bmsf_irq.sv
module bmsf_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clear_i,
  output logic irq_o
);
  logic status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      status_q <= 1'b0;
    else if (clear_i) status_q <= 1'b0;
    else if (set_i)   status_q <= 1'b1;
  end

  assign irq_o = status_q;

  p_clear_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !irq_o);
  p_set_on_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clear_i) |=> irq_o);
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clear_i) |=> irq_o);
endmodule

// File: rtl/bm_sec_filter.sv
module bm_sec_filter
  import bmsf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int SW = 2,
  parameter int NREG = 4,
  parameter logic [NREG*AW-1:0] REG_BASE  = {32'h1000_8000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
  parameter logic [NREG*AW-1:0] REG_LIMIT = {32'h1001_0FFF, 32'h2000_FFFF, 32'h1000_FFFF, 32'h0000_0FFF},
  parameter logic [NREG-1:0] REG_EX = 4'b0001,
  parameter logic [NREG-1:0] REG_NS = 4'b1100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_nonsec_i,
  input  logic          cfg_err_resp_i,
  input  logic          irq_clear_i,
  output logic          irq_o,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [SW-1:0] req_size_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          dn_valid_o,
  output logic          dn_write_o,
  output logic [AW-1:0] dn_addr_o,
  output logic [SW-1:0] dn_size_o,
  output logic [DW-1:0] dn_wdata_o,
  output logic          dn_nonsec_o,
  input  logic          dn_rsp_valid_i,
  input  logic          dn_rsp_err_i,
  input  logic [DW-1:0] dn_rdata_i
);
  logic  cfg_ns_q, cfg_err_q;
  st_e   st_q;
  attr_t attr;
  act_e  act;
  logic  accept, blk_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_ns_q  <= 1'b0;
      cfg_err_q <= 1'b0;
    end else begin
      cfg_ns_q  <= cfg_nonsec_i;
      cfg_err_q <= cfg_err_resp_i;
    end
  end

  bmsf_attr_table #(
    .AW(AW), .NREG(NREG), .BASE(REG_BASE), .LIMIT(REG_LIMIT),
    .EX_MASK(REG_EX), .NS_MASK(REG_NS)
  ) u_attr (
    .addr_i(req_addr_i),
    .attr_o(attr)
  );

  bmsf_decide u_dec (
    .attr_i   (attr),
    .cfg_ns_i (cfg_ns_q),
    .cfg_err_i(cfg_err_q),
    .act_o    (act)
  );

  assign accept  = (st_q == ST_IDLE) && req_valid_i;
  assign blk_err = accept && (act == ACT_ERR);

  bmsf_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (blk_err),
    .clear_i(irq_clear_i),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
      dn_valid_o  <= 1'b0;
      dn_write_o  <= 1'b0;
      dn_addr_o   <= '0;
      dn_size_o   <= '0;
      dn_wdata_o  <= '0;
      dn_nonsec_o <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      dn_valid_o  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            unique case (act)
              ACT_SEC, ACT_NS: begin
                dn_valid_o  <= 1'b1;
                dn_write_o  <= req_write_i;
                dn_addr_o   <= req_addr_i;
                dn_size_o   <= req_size_i;
                dn_wdata_o  <= req_wdata_i;
                dn_nonsec_o <= (act == ACT_NS);
                st_q        <= ST_WAIT;
              end
              default: begin
                rsp_valid_o <= 1'b1;
                rsp_err_o   <= (act == ACT_ERR);
                rsp_rdata_o <= '0;
              end
            endcase
          end
        end
        ST_WAIT: begin
          if (dn_rsp_valid_i) begin
            rsp_valid_o <= 1'b1;
            rsp_err_o   <= dn_rsp_err_i;
            rsp_rdata_o <= dn_rdata_i;
            st_q        <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_blk_no_dn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (act == ACT_ERR || act == ACT_RAZ)) |=> (!dn_valid_o && rsp_valid_o));
  p_ns_attr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !attr.exempt && attr.nonsec) |=> (dn_valid_o && dn_nonsec_o));
  p_raz_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && act == ACT_RAZ) |=> (rsp_rdata_o == '0 && !rsp_err_o));
  p_rsp_after_dn_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && dn_rsp_valid_i) |=> rsp_valid_o);
  p_dn_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |=> !dn_valid_o);
  p_busy_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !dn_rsp_valid_i) |=> (!rsp_valid_o && !dn_valid_o));
endmodule

// File: tb/sim_bm_sec_filter.sv
`timescale 1ns/1ps
module sim_bm_sec_filter;
  logic clk = 0, rst_n = 0;
  logic cfg_ns = 0, cfg_er = 0, clr = 0;
  logic req_v = 0, req_w = 0;
  logic [31:0] req_a = '0;
  logic [1:0] req_s = '0;
  logic [63:0] req_d = '0;
  logic dr_v = 0, dr_e = 0;
  logic [63:0] dr_d = '0;
  logic irq, rv, re, dv, dw, dns;
  logic [63:0] rd, dd;
  logic [31:0] da;
  logic [1:0] ds;

  int n_chk = 0, n_fail = 0;
  logic irq_m = 0, prev_ns = 0, prev_er = 0, done = 0;

  always #4 clk = ~clk;

  bm_sec_filter u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_nonsec_i(cfg_ns), .cfg_err_resp_i(cfg_er),
    .irq_clear_i(clr), .irq_o(irq), .req_valid_i(req_v), .req_write_i(req_w),
    .req_addr_i(req_a), .req_size_i(req_s), .req_wdata_i(req_d),
    .rsp_valid_o(rv), .rsp_err_o(re), .rsp_rdata_o(rd),
    .dn_valid_o(dv), .dn_write_o(dw), .dn_addr_o(da), .dn_size_o(ds),
    .dn_wdata_o(dd), .dn_nonsec_o(dns),
    .dn_rsp_valid_i(dr_v), .dn_rsp_err_i(dr_e), .dn_rdata_i(dr_d)
  );

  task automatic chk(input logic ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // 0 exempt, 1 secure, 2 non-secure (range), 3 unmatched
  function automatic int attr_of(input logic [31:0] a);
    if (a <= 32'h0000_0FFF) return 0;
    if (a >= 32'h1000_0000 && a <= 32'h1000_FFFF) return 1;
    if (a >= 32'h1000_8000 && a <= 32'h1001_0FFF) return 2;
    if (a >= 32'h2000_0000 && a <= 32'h2000_FFFF) return 2;
    return 3;
  endfunction

  task automatic access(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic ns, input logic er, input logic c, input int dly,
                        input logic late, input logic intrude);
    int at, cyc, cnt, exp_lat;
    logic got, saw, blk, tag_exp, eff_ns, eff_er, dn_err;
    logic [63:0] wd;
    string tr;
    wd = {a, ~a} ^ 64'h5A;
    at = attr_of(a);
    eff_ns = late ? prev_ns : ns;
    eff_er = late ? prev_er : er;
    blk = (at == 1) && eff_ns;
    tag_exp = (at == 0) ? eff_ns : (at == 1) ? 1'b0 : 1'b1;
    tr = (at == 0) ? "R1" : (at == 1) ? (blk ? "R4" : "R3") : (at == 2 ? "R11" : "R2");
    if (late) tr = "R12";
    dn_err = (a[11:0] == 12'hBAD);
    @(negedge clk);
    cfg_ns = ns; cfg_er = er;
    if (!late) @(negedge clk);
    req_v = 1; req_w = wr; req_a = a; req_s = sz; req_d = wd; clr = c;
    @(negedge clk);
    req_v = 0;
    cyc = 1; cnt = -1; got = 0; saw = 0;
    while (!got && cyc < 20) begin
      dr_v = 0;
      if (intrude) begin
        req_v = (cyc == 1); req_w = 1; req_a = 32'h1000_0010;
      end
      if (rv) got = 1;
      if (dv) begin
        saw = 1; cnt = dly;
        chk(dns == tag_exp, tr, dns, tag_exp);
        chk(da == a && ds == sz && dw == wr, "R9", {da, 30'd0, ds}, {a, 30'd0, sz});
        if (wr) chk(dd == wd, "R9", dd, wd);
      end
      if (cnt == 0) begin
        dr_v = 1; dr_e = dn_err; dr_d = {~a, a}; cnt = -1;
      end else if (cnt > 0) cnt--;
      if (!got) begin @(negedge clk); cyc++; end
    end
    dr_v = 0; req_v = 0;
    exp_lat = blk ? 1 : 2 + dly;
    chk(got && cyc == exp_lat, "R10", cyc, exp_lat);
    if (blk) begin
      chk(!saw, "R4", saw, 0);
      chk(re == eff_er, eff_er ? "R6" : "R5", re, eff_er);
      if (!wr) chk(rd == 64'd0, "R5", rd, 0);
      if (c) irq_m = 0; else if (eff_er) irq_m = 1;
    end else begin
      chk(saw, tr, saw, 1);
      chk(re == dn_err, "R9", re, dn_err);
      if (!wr) chk(rd == {~a, a}, "R9", rd, {~a, a});
      if (c) irq_m = 0;
    end
    chk(irq == irq_m, c ? "R7" : "R6", irq, irq_m);
    if (intrude) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(!rv && !dv && irq == irq_m, "R13", {rv, dv, irq}, {2'b00, irq_m});
      end
    end
    clr = 0;
    prev_ns = ns; prev_er = er;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] pts [10];
    pts = '{32'h0000_0000, 32'h0000_0FFF, 32'h0000_1000, 32'h1000_0000, 32'h1000_FFFF,
            32'h1000_8000, 32'h1001_0000, 32'h2000_0BAD, 32'h2000_8000, 32'h3000_0004};
    repeat (3) @(negedge clk);
    chk(!irq && !rv && !dv, "R8", {irq, rv, dv}, 0);
    rst_n = 1;
    // first access right after reset: registered config still secure
    access(0, 32'h1000_0000, 2'd2, 1, 1, 0, 0, 1, 0);
    for (int i = 0; i < 10; i++)
      for (int m = 0; m < 8; m++)
        access(m[0], pts[i], 2'(i + m), m[1], m[2], (m == 6 && i % 2 == 0), (i + m) % 3, 0, 0);
    // sticky then clear pulse
    access(1, 32'h1000_0020, 2'd3, 1, 1, 0, 0, 0, 0);
    chk(irq == 1, "R6", irq, 1);
    access(0, 32'h2000_0000, 2'd0, 1, 1, 0, 1, 0, 0);
    chk(irq == 1, "R7", irq, 1);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    irq_m = 0;
    chk(irq == 0, "R7", irq, 0);
    // clear held while error block happens
    access(0, 32'h1000_0040, 2'd1, 1, 1, 1, 0, 0, 0);
    // late config change ignored for that request
    access(0, 32'h1000_0080, 2'd2, 0, 0, 0, 0, 0, 0);
    access(0, 32'h1000_0080, 2'd2, 1, 1, 0, 0, 1, 0);
    access(1, 32'h1000_0080, 2'd2, 0, 0, 0, 0, 1, 0);
    // request while busy
    access(0, 32'h2000_0100, 2'd3, 1, 1, 0, 2, 0, 1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule